// File: doc/BRIEF.md
# Four-State Snooping Line-State Controller

This block keeps the coherence state of a small, directly indexed set of cache lines for one write-back, write-allocate cache on a shared snooping bus. Each line is in one of four states: invalid, shared-clean, exclusive-clean or modified. The controller answers two sources of events. One is the local processor's loads and stores. The other is read and read-for-ownership transactions from other caches that it observes on the bus.

Address bits split into a line index (low bits) and a tag (high bits), and each index holds exactly one line. On a processor miss, the controller may first write back a dirty victim. It then requests the line with a bus read or a bus read-for-ownership. For a plain read it samples the wired-OR shared signal when its read is granted, and uses it to choose between the exclusive and shared states. A line that was read alone and then written therefore costs one bus transaction instead of two. On a snoop hit, the controller raises its shared output, flushes dirty data where needed and downgrades or drops its copy.

The bus is atomic: a granted request completes in the grant cycle, and the grant never falls in a cycle that carries a snoop.

Top module: `mesi_coherence_ctrl`

## Requirements
- R1: After reset every line is invalid, the processor side is idle, `cpu_done` and `bus_req` are low, and the first access to any address must go to the bus.
- R2: A read that misses raises `bus_req` with `bus_cmd` = 0 (read) and the requested address. When granted, the line becomes exclusive-clean if `bus_shared_in` is low and shared-clean if it is high. `cpu_done` pulses in the grant cycle.
- R3: A write to an exclusive-clean line completes in its request cycle with no bus request, and the line becomes modified.
- R4: A write to a shared-clean or missing line raises `bus_req` with `bus_cmd` = 1 (read-for-ownership). When granted, the line becomes modified.
- R5: Reads hitting any valid state, and writes hitting a modified line, raise `cpu_done` in the request cycle with no bus request.
- R6: A snooped read (`snp_cmd` = 0) hitting a modified line raises `snp_flush` in that cycle, and the line becomes shared-clean.
- R7: A snooped read hitting an exclusive-clean line leaves `snp_flush` low, and the line becomes shared-clean.
- R8: A snooped read-for-ownership (`snp_cmd` = 1) invalidates a hit line. It raises `snp_flush` only if the line was modified.
- R9: `snp_shared` is high in exactly the cycles where a snooped read or read-for-ownership matches the tag of a valid line at its index.
- R10: A miss whose index holds a modified line first issues `bus_cmd` = 2 (flush) with the victim's address. Only after that grant does it request the new line. An exclusive-clean or shared-clean victim is replaced with no flush.
- R11: When a snoop names the index of a pending processor request in the same cycle, the snoop acts first. The processor access is not completed in that cycle and is decided in a later cycle against the updated state.
- R12: If a pending victim write-back loses its modified state to a snoop before it is granted, the write-back is dropped and the line fetch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor access pending; held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load; held with the request |
| cpu_addr | input | TAG_W+IDX_W | Line address {tag, index}; held with the request |
| cpu_done | output | 1 | Access completes in this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 flush |
| bus_addr | output | TAG_W+IDX_W | Address of the requested transaction |
| bus_gnt | input | 1 | Request granted and completed this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line, sampled on a granted read |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 1 | 0 read, 1 read-for-ownership |
| snp_addr | input | TAG_W+IDX_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data for the snoop |

## Verification
Two events can land in the same cycle: a processor access and a snoop to the same line index. The bench provokes this by raising a snoop on the first cycle of a held request (R11). It also raises a snoop in the cycle where a victim write-back waits for its grant (R12). A behavioural per-line model in the bench applies the snoop before the processor decision. On every clock it judges whether `cpu_done`, the bus command and address, and the snoop responses match what the requirements prescribe for that ordering.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BC_READ  = 2'd0,
    BC_READX = 2'd1,
    BC_FLUSH = 2'd2
  } bus_cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_EVICT = 2'd1,
    PH_FILL  = 2'd2
  } phase_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter  int IDX_W = 2,
  parameter  int TAG_W = 4,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_t         snp_st,
  input  logic             own_en,
  input  logic [IDX_W-1:0] own_idx,
  input  line_st_t         own_st,
  input  logic             own_tag_en,
  input  logic [TAG_W-1:0] own_tag,
  output line_st_t         st_o  [LINES],
  output logic [TAG_W-1:0] tag_o [LINES]
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_t         st_q, st_d;
    logic [TAG_W-1:0] tag_q;
    logic             snp_sel, own_sel, st_en, tag_en;

    // a snoop outranks the local side when both name this line
    always_comb begin
      snp_sel = snp_en && (snp_idx == IDX_W'(g));
      own_sel = own_en && (own_idx == IDX_W'(g));
      st_en   = snp_sel || own_sel;
      st_d    = snp_sel ? snp_st : own_st;
      tag_en  = own_sel && own_tag_en && !snp_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q <= LS_INV;
      else if (st_en) st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= '0;
      else if (tag_en) tag_q <= own_tag;
    end

    assign st_o[g]  = st_q;
    assign tag_o[g] = tag_q;
  end
endmodule

// File: rtl/mesi_snoop.sv
module mesi_snoop
  import mesi_pkg::*;
#(
  parameter  int IDX_W  = 2,
  parameter  int TAG_W  = 4,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              snp_valid,
  input  logic              snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_t          st_i  [LINES],
  input  logic [TAG_W-1:0]  tag_i [LINES],
  output logic [IDX_W-1:0]  snp_idx,
  output logic              snp_hit,
  output logic              snp_dirty,
  output line_st_t          snp_next
);
  line_st_t cur;

  always_comb begin
    snp_idx   = snp_addr[IDX_W-1:0];
    cur       = st_i[snp_idx];
    snp_hit   = snp_valid && (cur != LS_INV) &&
                (tag_i[snp_idx] == snp_addr[ADDR_W-1:IDX_W]);
    snp_dirty = snp_hit && (cur == LS_MOD);
    // read-for-ownership drops the copy, plain read leaves a clean sharer
    snp_next  = snp_cmd ? LS_INV : LS_SHR;
  end
endmodule

// File: rtl/mesi_cpu_ctl.sv
module mesi_cpu_ctl
  import mesi_pkg::*;
#(
  parameter  int IDX_W  = 2,
  parameter  int TAG_W  = 4,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              conflict,
  input  line_st_t          cur_st,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  output logic              cpu_done,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              wr_en,
  output line_st_t          wr_st,
  output logic              tag_en
);
  phase_t phase_q, phase_d;
  logic   hit;

  always_comb begin
    hit      = (cur_st != LS_INV) && (cur_tag == cpu_addr[ADDR_W-1:IDX_W]);
    phase_d  = phase_q;
    cpu_done = 1'b0;
    bus_req  = 1'b0;
    bus_cmd  = BC_READ;
    bus_addr = cpu_addr;
    wr_en    = 1'b0;
    wr_st    = LS_INV;
    tag_en   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (cpu_req && !conflict) begin
          if (hit && (!cpu_we || cur_st == LS_MOD)) begin
            cpu_done = 1'b1;
          end else if (hit && cur_st == LS_EXC) begin
            cpu_done = 1'b1;
            wr_en    = 1'b1;
            wr_st    = LS_MOD;
          end else if (hit) begin
            phase_d  = PH_FILL;
          end else begin
            phase_d  = (cur_st == LS_MOD) ? PH_EVICT : PH_FILL;
          end
        end
      end
      PH_EVICT: begin
        if (cur_st != LS_MOD) begin
          phase_d = PH_FILL;
        end else begin
          bus_req  = 1'b1;
          bus_cmd  = BC_FLUSH;
          bus_addr = {cur_tag, cpu_addr[IDX_W-1:0]};
          if (bus_gnt) begin
            wr_en   = 1'b1;
            wr_st   = LS_INV;
            phase_d = PH_FILL;
          end
        end
      end
      PH_FILL: begin
        bus_req = 1'b1;
        bus_cmd = cpu_we ? BC_READX : BC_READ;
        if (bus_gnt) begin
          cpu_done = 1'b1;
          wr_en    = 1'b1;
          tag_en   = 1'b1;
          wr_st    = cpu_we ? LS_MOD : (bus_shared_in ? LS_SHR : LS_EXC);
          phase_d  = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R10: a granted write-back is always followed by the fetch of the new line
  a_r10_fill_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_FLUSH) |=> (phase_q == PH_FILL));

  // R12: a line that left the modified state is not written back
  a_r12_no_stale_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_EVICT && cur_st != LS_MOD) |=> (phase_q == PH_FILL));

  // request must stay put while the controller works on it
  a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (cpu_req && $stable(cpu_addr) && $stable(cpu_we)));
endmodule

// File: rtl/mesi_coherence_ctrl.sv
module mesi_coherence_ctrl
  import mesi_pkg::*;
#(
  parameter  int IDX_W  = 2,
  parameter  int TAG_W  = 4,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int LINES  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic              snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_flush
);
  logic             rst_meta_q, rst_sync_n;
  line_st_t         st_arr  [LINES];
  logic [TAG_W-1:0] tag_arr [LINES];
  logic [IDX_W-1:0] snp_idx, cpu_idx;
  logic             snp_hit, snp_dirty, conflict;
  line_st_t         snp_next, wr_st;
  logic             wr_en, tag_en;
  bus_cmd_t         bus_cmd_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  assign cpu_idx  = cpu_addr[IDX_W-1:0];
  assign conflict = snp_valid && (snp_idx == cpu_idx);

  mesi_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .st_i      (st_arr),
    .tag_i     (tag_arr),
    .snp_idx   (snp_idx),
    .snp_hit   (snp_hit),
    .snp_dirty (snp_dirty),
    .snp_next  (snp_next)
  );

  mesi_cpu_ctl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cpu_req       (cpu_req),
    .cpu_we        (cpu_we),
    .cpu_addr      (cpu_addr),
    .conflict      (conflict),
    .cur_st        (st_arr[cpu_idx]),
    .cur_tag       (tag_arr[cpu_idx]),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .cpu_done      (cpu_done),
    .bus_req       (bus_req),
    .bus_cmd       (bus_cmd_e),
    .bus_addr      (bus_addr),
    .wr_en         (wr_en),
    .wr_st         (wr_st),
    .tag_en        (tag_en)
  );

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .snp_en     (snp_hit),
    .snp_idx    (snp_idx),
    .snp_st     (snp_next),
    .own_en     (wr_en),
    .own_idx    (cpu_idx),
    .own_st     (wr_st),
    .own_tag_en (tag_en),
    .own_tag    (cpu_addr[ADDR_W-1:IDX_W]),
    .st_o       (st_arr),
    .tag_o      (tag_arr)
  );

  assign bus_cmd    = bus_cmd_e;
  assign snp_shared = snp_hit;
  assign snp_flush  = snp_dirty;

  // the bus carries one transaction per cycle
  a_r11_one_bus_owner: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_gnt) |-> !snp_valid);

  a_r2_fill_state: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_gnt && bus_cmd == 2'd0) |=>
    (st_arr[$past(bus_addr[IDX_W-1:0])] == ($past(bus_shared_in) ? LS_SHR : LS_EXC)));

  a_r4_owned_after_rfo: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_gnt && bus_cmd == 2'd1) |=>
    (st_arr[$past(bus_addr[IDX_W-1:0])] == LS_MOD));

  a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_done && cpu_we && !bus_req) |=> (st_arr[$past(cpu_idx)] == LS_MOD));

  a_r6_read_demotes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (snp_shared && !snp_cmd) |=> (st_arr[$past(snp_idx)] == LS_SHR));

  a_r8_rfo_invalidates: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (snp_shared && snp_cmd) |=> (st_arr[$past(snp_idx)] == LS_INV));

  a_r10_victim_dirty: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_req && bus_cmd == 2'd2) |->
    (st_arr[bus_addr[IDX_W-1:0]] == LS_MOD &&
     tag_arr[bus_addr[IDX_W-1:0]] == bus_addr[ADDR_W-1:IDX_W]));

  a_r11_snoop_first: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_done |-> !conflict);
endmodule

// File: tb/mesi_coherence_ctrl_test.sv
module mesi_coherence_ctrl_test;
  localparam int IW = 2;
  localparam int TW = 4;
  localparam int AW = IW + TW;
  localparam int NL = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we, bus_gnt, bus_shared_in, snp_valid, snp_cmd;
  logic [AW-1:0] cpu_addr, snp_addr, bus_addr;
  logic          cpu_done, bus_req, snp_shared, snp_flush;
  logic [1:0]    bus_cmd;

  always #10 clk = ~clk;

  mesi_coherence_ctrl #(.IDX_W(IW), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // model: 0 invalid, 1 shared, 2 exclusive, 3 modified; phase 0 idle, 1 evict, 2 fill
  int m_st [NL];
  int m_tag[NL];
  int m_ph;
  bit e_done, e_req, e_sh, e_fl, n_wr, n_tw;
  int e_cmd, e_addr, n_ph, n_wst;

  function automatic void predict();
    int ci = int'(cpu_addr[IW-1:0]);
    int ct = int'(cpu_addr[AW-1:IW]);
    int si = int'(snp_addr[IW-1:0]);
    int sg = int'(snp_addr[AW-1:IW]);
    bit conf, hit;
    e_sh = snp_valid && m_st[si] != 0 && m_tag[si] == sg;
    e_fl = e_sh && m_st[si] == 3;
    conf = snp_valid && si == ci;
    hit  = m_st[ci] != 0 && m_tag[ci] == ct;
    e_done = 0; e_req = 0; e_cmd = 0; e_addr = 0;
    n_ph = m_ph; n_wr = 0; n_wst = 0; n_tw = 0;
    case (m_ph)
      0: if (cpu_req && !conf) begin
        if (hit && (!cpu_we || m_st[ci] == 3)) e_done = 1;
        else if (hit && m_st[ci] == 2) begin e_done = 1; n_wr = 1; n_wst = 3; end
        else if (hit) n_ph = 2;
        else n_ph = (m_st[ci] == 3) ? 1 : 2;
      end
      1: if (m_st[ci] != 3) n_ph = 2;
         else begin
           e_req = 1; e_cmd = 2; e_addr = m_tag[ci] * NL + ci;
           if (bus_gnt) begin n_wr = 1; n_wst = 0; n_ph = 2; end
         end
      default: begin
        e_req = 1; e_cmd = cpu_we ? 1 : 0; e_addr = int'(cpu_addr);
        if (bus_gnt) begin
          e_done = 1; n_wr = 1; n_tw = 1; n_ph = 0;
          n_wst = cpu_we ? 3 : (bus_shared_in ? 1 : 2);
        end
      end
    endcase
  endfunction

  function automatic void apply();
    int ci = int'(cpu_addr[IW-1:0]);
    int si = int'(snp_addr[IW-1:0]);
    if (e_sh) m_st[si] = snp_cmd ? 0 : 1;
    if (n_wr) m_st[ci] = n_wst;
    if (n_tw) m_tag[ci] = int'(cpu_addr[AW-1:IW]);
    m_ph = n_ph;
  endfunction

  task automatic chk(string r, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // inputs are set after a falling edge; outputs judged 5 ns before the rising edge
  task automatic run_cycle(string r);
    predict();
    #5;
    chk(r, "cpu_done", int'(cpu_done), int'(e_done));
    chk(r, "bus_req", int'(bus_req), int'(e_req));
    if (e_req) begin
      chk(r, "bus_cmd", int'(bus_cmd), e_cmd);
      chk(r, "bus_addr", int'(bus_addr), e_addr);
    end
    chk(r, "snp_shared", int'(snp_shared), int'(e_sh));
    chk(r, "snp_flush", int'(snp_flush), int'(e_fl));
    @(posedge clk);
    apply();
    @(negedge clk);
  endtask

  task automatic access(bit we, int addr, bit shin, int snoop_at, bit scmd,
                        int saddr, int gnt_hold, string r);
    bit got = 0;
    cpu_req = 1; cpu_we = we; cpu_addr = AW'(addr); bus_shared_in = shin;
    for (int k = 0; k < 12 && !got; k++) begin
      snp_valid = (k == snoop_at); snp_cmd = scmd; snp_addr = AW'(saddr);
      bus_gnt = 0;
      predict();
      bus_gnt = e_req && !snp_valid && (k >= gnt_hold);
      run_cycle(r);
      got = e_done;
    end
    if (!got) chk(r, "access completes", 0, 1);
    cpu_req = 0; snp_valid = 0; bus_gnt = 0;
  endtask

  task automatic snoop(bit scmd, int saddr, string r);
    snp_valid = 1; snp_cmd = scmd; snp_addr = AW'(saddr);
    run_cycle(r);
    snp_valid = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    m_ph = 0;
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; bus_gnt = 0;
    bus_shared_in = 0; snp_valid = 0; snp_cmd = 0; snp_addr = '0;
    repeat (3) @(negedge clk);
    #5;
    chk("R1", "reset cpu_done", int'(cpu_done), 0);
    chk("R1", "reset bus_req", int'(bus_req), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: nothing is valid after reset, so a snoop misses and a read goes out
    snoop(0, 'h05, "R1");
    access(0, 'h05, 0, -1, 0, 0, 0, "R1");
    // R3 silent upgrade, then R5 hits
    access(1, 'h05, 0, -1, 0, 0, 0, "R3");
    access(0, 'h05, 0, -1, 0, 0, 0, "R5");
    access(1, 'h05, 0, -1, 0, 0, 0, "R5");
    // R6 dirty read snoop, then R4 upgrade from shared
    snoop(0, 'h05, "R6");
    access(0, 'h05, 0, -1, 0, 0, 0, "R5");
    access(1, 'h05, 0, -1, 0, 0, 0, "R4");
    // R8 read-for-ownership on a dirty line, line then misses
    snoop(1, 'h05, "R8");
    access(0, 'h05, 0, -1, 0, 0, 2, "R2");
    // R2 shared fill with delayed grant, R9 clean sharer answers
    access(0, 'h0a, 1, -1, 0, 0, 3, "R2");
    snoop(0, 'h0a, "R9");
    access(1, 'h0a, 0, -1, 0, 0, 0, "R4");
    // R7 exclusive line demoted without flush; the write then needs the bus
    access(0, 'h03, 0, -1, 0, 0, 0, "R2");
    snoop(0, 'h03, "R7");
    access(1, 'h03, 0, -1, 0, 0, 0, "R4");
    // R8 clean line invalidated without flush
    access(0, 'h00, 0, -1, 0, 0, 0, "R2");
    snoop(1, 'h00, "R8");
    access(0, 'h00, 0, -1, 0, 0, 0, "R8");
    // R9 tag mismatch at a valid index gets no answer
    snoop(0, 'h10, "R9");
    snoop(1, 'h20, "R9");
    // R10 dirty victim written back, then clean victim replaced silently
    access(1, 'h05, 0, -1, 0, 0, 0, "R3");
    access(0, 'h15, 0, -1, 0, 0, 1, "R10");
    access(0, 'h30, 0, -1, 0, 0, 0, "R10");
    // R11 snoop and store to the same index in one cycle
    access(1, 'h15, 0, 0, 1, 'h15, 0, "R11");
    access(0, 'h31, 0, 0, 0, 'h30, 0, "R11");
    // R12 victim loses its dirty state while its write-back waits
    access(0, 'h1a, 0, 1, 0, 'h0a, 2, "R12");
    snoop(0, 'h0a, "R12");
    finished = 1;
    summary();
    $finish;
  end
endmodule